// File: doc/BRIEF.md
# Three-Leg Phase-Shifted Gate Pattern Generator

This block produces the twelve gate commands for a three-leg, three-level bridge in which every leg carries four switches. A free-running period counter, clocked by the system clock, defines one switching period. From it each leg derives two square waves of fixed half-period width. The leading wave drives the outer switch pair: the wave itself goes to the top switch and its complement to the bottom switch. The lagging wave drives the inner switch pair in the same way. The converter's output is set only by how far the lagging wave trails the leading wave. Pulse widths never change.

The three legs share one counter and use one leg offset, about a third of the period, so their leading edges stay 120 degrees apart. The commanded lag is the same for all legs. It is capped at that same offset, because larger lags no longer move the output. Every gate goes through its own rising-edge delay, so that the two complementary switches of a pair are never commanded on together. The period, lag and delay commands are taken in only at a period boundary. A change made in mid-period therefore never shortens a pulse.

The control loop that computes the lag command stays outside the block. There is no data stream at the edge: all inputs are plain control levels and all outputs are plain gate levels. The block has no valid/ready handshake and exerts no back-pressure.

Top module: `tri_leg_pwm_gen`

## Requirements
- R1: With effective period P, H = floor(P/2) and dead count d, every gate with even index is high for H-d clocks per period and every gate with odd index is high for P-H-d clocks per period.
- R2: Gate index 4k+r belongs to leg k (k = 0..2). Role r=0 is the outer top switch (leading wave). Role r=1 is the outer bottom switch (complement of the leading wave). Role r=2 is the inner top switch (lagging wave). Role r=3 is the inner bottom switch (complement of the lagging wave). The rise of role 1 trails the rise of role 0 by H clocks, and the rise of role 3 trails the rise of role 2 by H clocks.
- R3: The lagging wave of every leg rises S clocks after that leg's leading wave, where S = min(shift command, F). The same S applies to all three legs.
- R4: A shift command above F is clamped to exactly F.
- R5: The leading wave of leg k rises k*F clocks (mod P) after the leading wave of leg 0, where F = floor((P+1)/3), the period divided by three and rounded to the nearest clock.
- R6: Each gate's rising edge is delayed by the dead count d, and its falling edge is not delayed. The two gates of a complementary pair (4k and 4k+1, 4k+2 and 4k+3) are never high in the same cycle.
- R7: Period, shift and dead commands take effect only at a period boundary. The period in progress keeps its length when the period command changes in mid-period.
- R8: While reset is asserted all twelve gates are low. One clock after enable is sampled low, all twelve gates are low.
- R9: Switching restarts at the start of a period. Counting the first rising clock edge that samples enable high as edge 1, gate 0 first reads high after edge 3+d.
- R10: A period command below 6 is treated as a period of 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low forces all gates low |
| period_cmd | input | CNT_W | Switching period in clocks |
| shift_cmd | input | CNT_W | Lag of the inner pair behind the outer pair, in clocks |
| dead_cmd | input | DEAD_W | Rising-edge delay applied to every gate, in clocks |
| gate_o | output | 12 | Gate commands, index 4*leg + role |

## Verification
A wrong period counter or a wrong latched period appears within one period as a gate-0 rise-to-rise interval that differs from the commanded length. A wrong leg offset or a wrong lag clamp appears within the same period as a rise of gate 4k or gate 4k+2 at the wrong distance from gate 0. A fault in a dead-time counter appears at the very next rising edge of that gate, either as a shortened high time or as a cycle in which both gates of a pair are high. A mistake in the enable or restart logic appears one clock after enable changes, or at the first gate-0 rise, which must come 3+d clocks after enable.

// File: rtl/tlpg_pkg.sv
package tlpg_pkg;
  // Leg and gate counts of the bridge.
  localparam int LEGS          = 3;
  localparam int GATES_PER_LEG = 4;
  localparam int NUM_GATES     = LEGS * GATES_PER_LEG;

  // Role of a gate inside its leg (index within the 4-bit leg group).
  localparam int ROLE_OUT_HI = 0;  // leading wave
  localparam int ROLE_OUT_LO = 1;  // complement of leading wave
  localparam int ROLE_IN_HI  = 2;  // lagging wave
  localparam int ROLE_IN_LO  = 3;  // complement of lagging wave
endpackage

// File: rtl/tlpg_period_timer.sv
// Shared period counter plus the command registers that are refreshed
// only at a period boundary (or while idle).
module tlpg_period_timer #(
  parameter int CW   = 16,
  parameter int DW   = 8,
  parameter int MINP = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] period_cmd,
  input  logic [CW-1:0] shift_cmd,
  input  logic [DW-1:0] dead_cmd,
  output logic          run,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] per_l,
  output logic [CW-1:0] half_l,
  output logic [CW-1:0] off_l,
  output logic [CW-1:0] sh_l,
  output logic [DW-1:0] dead_l
);
  logic [CW-1:0] per_n, half_n, off_n, sh_n;
  logic [CW:0]   third_w;
  logic          last, load;

  // Next-period values derived from the raw commands (R10, R5, R4).
  always_comb begin
    per_n   = (period_cmd < CW'(MINP)) ? CW'(MINP) : period_cmd;
    half_n  = per_n >> 1;
    third_w = ({1'b0, per_n} + {{CW{1'b0}}, 1'b1}) / (CW+1)'(3);
    off_n   = third_w[CW-1:0];
    sh_n    = (shift_cmd > off_n) ? off_n : shift_cmd;
  end

  assign last = (cnt == per_l - CW'(1));
  assign load = !en || !run || last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      cnt    <= '0;
      per_l  <= CW'(MINP);
      half_l <= CW'(MINP / 2);
      off_l  <= CW'((MINP + 1) / 3);
      sh_l   <= '0;
      dead_l <= '0;
    end else begin
      if (!en) begin
        run <= 1'b0;
        cnt <= '0;
      end else if (!run) begin
        run <= 1'b1;
        cnt <= '0;
      end else begin
        cnt <= last ? '0 : cnt + CW'(1);
      end
      if (load) begin
        per_l  <= per_n;
        half_l <= half_n;
        off_l  <= off_n;
        sh_l   <= sh_n;
        dead_l <= dead_cmd;
      end
    end
  end
endmodule

// File: rtl/tlpg_leg_phase.sv
// Per-leg waveform: leading and lagging half-period waves and their
// complements, registered, positioned by the leg index.
module tlpg_leg_phase
  import tlpg_pkg::*;
#(
  parameter int CW  = 16,
  parameter int LEG = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     act,
  input  logic [CW-1:0]            cnt,
  input  logic [CW-1:0]            per,
  input  logic [CW-1:0]            half,
  input  logic [CW-1:0]            off,
  input  logic [CW-1:0]            shift,
  output logic [GATES_PER_LEG-1:0] raw
);
  localparam int XW = CW + 2;

  logic [XW-1:0] c_x, p_x, h_x, s_x, ofs_x, pos_x, lag_x;
  logic          lead, lag;

  always_comb begin
    c_x   = {2'b00, cnt};
    p_x   = {2'b00, per};
    h_x   = {2'b00, half};
    s_x   = {2'b00, shift};
    ofs_x = XW'(LEG) * {2'b00, off};
    pos_x = (c_x >= ofs_x) ? (c_x - ofs_x) : (c_x + p_x - ofs_x);
    lag_x = (pos_x >= s_x) ? (pos_x - s_x) : (pos_x + p_x - s_x);
    lead  = (pos_x < h_x);
    lag   = (lag_x < h_x);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw <= '0;
    end else if (!act) begin
      raw <= '0;
    end else begin
      raw[ROLE_OUT_HI] <= lead;
      raw[ROLE_OUT_LO] <= !lead;
      raw[ROLE_IN_HI]  <= lag;
      raw[ROLE_IN_LO]  <= !lag;
    end
  end
endmodule

// File: rtl/tlpg_dead_band.sv
// Rising-edge delay for one gate; falling edges pass at once.
module tlpg_dead_band #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          raw,
  input  logic [DW-1:0] dead,
  output logic          gate
);
  logic [DW-1:0] dc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dc   <= '0;
      gate <= 1'b0;
    end else if (!en || !raw) begin
      dc   <= '0;
      gate <= 1'b0;
    end else if (dc >= dead) begin
      gate <= 1'b1;
    end else begin
      dc <= dc + DW'(1);
    end
  end
endmodule

// File: rtl/tri_leg_pwm_gen.sv
module tri_leg_pwm_gen
  import tlpg_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DEAD_W     = 8,
  parameter int MIN_PERIOD = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [CNT_W-1:0]     period_cmd,
  input  logic [CNT_W-1:0]     shift_cmd,
  input  logic [DEAD_W-1:0]    dead_cmd,
  output logic [NUM_GATES-1:0] gate_o
);
  logic                 run, act;
  logic [CNT_W-1:0]     cnt, per_l, half_l, off_l, sh_l;
  logic [DEAD_W-1:0]    dead_l;
  logic [NUM_GATES-1:0] raw;

  tlpg_period_timer #(.CW(CNT_W), .DW(DEAD_W), .MINP(MIN_PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(en),
    .period_cmd(period_cmd), .shift_cmd(shift_cmd), .dead_cmd(dead_cmd),
    .run(run), .cnt(cnt), .per_l(per_l), .half_l(half_l),
    .off_l(off_l), .sh_l(sh_l), .dead_l(dead_l)
  );

  assign act = run && en;

  for (genvar k = 0; k < LEGS; k++) begin : g_leg
    tlpg_leg_phase #(.CW(CNT_W), .LEG(k)) u_leg (
      .clk(clk), .rst_n(rst_n), .act(act), .cnt(cnt),
      .per(per_l), .half(half_l), .off(off_l), .shift(sh_l),
      .raw(raw[k*GATES_PER_LEG +: GATES_PER_LEG])
    );
  end

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    tlpg_dead_band #(.DW(DEAD_W)) u_db (
      .clk(clk), .rst_n(rst_n), .en(en), .raw(raw[g]),
      .dead(dead_l), .gate(gate_o[g])
    );
  end
endmodule

// File: rtl/tlpg_chk.sv
module tlpg_chk #(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          run,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] per_l,
  input logic [CW-1:0] off_l,
  input logic [CW-1:0] sh_l,
  input logic [DW-1:0] dead_l,
  input logic [11:0]   gate
);
  // R6: complementary pairs never on together
  a_r6_pair_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate[0] & gate[1]) | (gate[2] & gate[3]) | (gate[4] & gate[5]) |
     (gate[6] & gate[7]) | (gate[8] & gate[9]) | (gate[10] & gate[11])) == 1'b0);

  // R8: enable low clears all gates one clock later
  a_r8_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (gate == 12'h000));

  // R7: commands hold still except at the period boundary
  a_r7_hold_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != '0) |-> ($stable(per_l) && $stable(sh_l) && $stable(dead_l)));

  // R7: counter stays inside the latched period
  a_r7_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < per_l));

  // R4: applied lag never exceeds the leg offset
  a_r4_shift_cap: assert property (@(posedge clk) disable iff (!rst_n)
    sh_l <= off_l);

  // R8: reset holds gates low
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r8_reset_low: assert (gate == 12'h000);
    end
  end
endmodule

bind tri_leg_pwm_gen tlpg_chk #(.CW(CNT_W), .DW(DEAD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .run(run), .cnt(cnt),
  .per_l(per_l), .off_l(off_l), .sh_l(sh_l), .dead_l(dead_l),
  .gate(gate_o)
);

// File: tb/tri_leg_pwm_gen_tb.sv
module tri_leg_pwm_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] period_cmd = 16'd24;
  logic [15:0] shift_cmd = 16'd0;
  logic [7:0]  dead_cmd = 8'd0;
  logic [11:0] gate_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  tri_leg_pwm_gen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .period_cmd(period_cmd),
    .shift_cmd(shift_cmd), .dead_cmd(dead_cmd), .gate_o(gate_o)
  );

  // Vectors: period command, shift command, dead count
  localparam int NV = 7;
  localparam int VP [NV] = '{24, 24, 30, 26, 32, 2, 28};
  localparam int VS [NV] = '{4, 20, 0, 5, 11, 1, 15};
  localparam int VD [NV] = '{1, 2, 0, 3, 1, 1, 2};

  logic [11:0] sbuf [0:127];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_rise(output int n);
    logic prev;
    prev = gate_o[0];
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      n++;
      if (gate_o[0] && !prev) break;
      prev = gate_o[0];
    end
  endtask

  task automatic run_vector(input int p, input int s, input int d);
    int pe, hf, of, se, rref, ov;
    pe = (p < 6) ? 6 : p;              // R10
    hf = pe / 2;
    of = (pe + 1) / 3;                 // R5
    se = (s > of) ? of : s;            // R3, R4
    @(negedge clk);
    en = 1'b0;
    period_cmd = 16'(p);
    shift_cmd = 16'(s);
    dead_cmd = 8'(d);
    repeat (3) @(negedge clk);
    en = 1'b1;
    repeat (4 * pe) @(negedge clk);
    for (int i = 0; i < 3 * pe; i++) begin
      sbuf[i] = gate_o;
      @(negedge clk);
    end
    rref = -1;
    for (int i = 1; i < 3 * pe; i++) begin
      if (rref < 0 && sbuf[i][0] && !sbuf[i-1][0]) rref = i;
    end
    if (rref < 0) rref = 1;
    for (int g = 0; g < 12; g++) begin
      int k, r, eo, ao, aw, ew;
      k = g / 4;
      r = g % 4;
      eo = k * of + ((r >= 2) ? se : 0) + ((r % 2 == 1) ? hf : 0);
      eo = eo % pe;
      ew = (r % 2 == 0) ? (hf - d) : (pe - hf - d);
      ao = -1;
      aw = 0;
      for (int j = rref; j < rref + pe; j++) begin
        if (ao < 0 && sbuf[j][g] && !sbuf[j-1][g]) ao = j - rref;
        if (sbuf[j][g]) aw++;
      end
      if (r == 0)
        chk(ao == eo, $sformatf("R5 leg offset p=%0d gate %0d", p, g), ao, eo);
      else if (r == 1)
        chk(ao == eo, $sformatf("R2 complement p=%0d gate %0d", p, g), ao, eo);
      else if (s > of)
        chk(ao == eo, $sformatf("R4 clamped lag p=%0d gate %0d", p, g), ao, eo);
      else
        chk(ao == eo, $sformatf("R3 lag p=%0d gate %0d", p, g), ao, eo);
      if (p < 6)
        chk(aw == ew, $sformatf("R10 width p=%0d gate %0d", p, g), aw, ew);
      else
        chk(aw == ew, $sformatf("R1 width p=%0d gate %0d", p, g), aw, ew);
    end
    ov = 0;
    for (int i = 0; i < 3 * pe; i++) begin
      for (int k = 0; k < 12; k += 2) begin
        if (sbuf[i][k] && sbuf[i][k+1]) ov++;
      end
    end
    chk(ov == 0, $sformatf("R6 pair overlap p=%0d", p), ov, 0);
  endtask

  initial begin
    int n, n1, n2, n3;
    // R8: reset holds gates low even with enable high
    en = 1'b1;
    repeat (4) @(negedge clk);
    chk(gate_o == 12'h000, "R8 reset low", int'(gate_o), 0);
    en = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(gate_o == 12'h000, "R8 idle low", int'(gate_o), 0);

    for (int v = 0; v < NV; v++) run_vector(VP[v], VS[v], VD[v]);

    // R9: restart at period start, gate 0 high after edge 3+d
    en = 1'b0;
    period_cmd = 16'd24;
    shift_cmd = 16'd4;
    dead_cmd = 8'd1;
    repeat (3) @(negedge clk);
    en = 1'b1;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      n++;
      if (gate_o[0]) break;
    end
    chk(n == 4, "R9 first rise", n, 4);

    // R7: period change in mid-period waits for the boundary
    en = 1'b0;
    dead_cmd = 8'd0;
    repeat (3) @(negedge clk);
    en = 1'b1;
    wait_rise(n);
    wait_rise(n);
    repeat (7) @(negedge clk);
    period_cmd = 16'd30;
    shift_cmd = 16'd9;
    wait_rise(n1);
    wait_rise(n2);
    wait_rise(n3);
    chk(n1 + 7 == 24, "R7 current period kept", n1 + 7, 24);
    chk(n2 == 30, "R7 new period", n2, 30);
    chk(n3 == 30, "R7 new period steady", n3, 30);

    // R8: enable low clears gates one clock later
    repeat (5) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(gate_o == 12'h000, "R8 disable", int'(gate_o), 0);
    repeat (5) @(negedge clk);
    chk(gate_o == 12'h000, "R8 disable held", int'(gate_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule